// File: doc/BRIEF.md
# Framed four-bit pattern checker

This block watches a serial stream of single bits and cuts it into back-to-back frames of four bits that do not overlap. The first bit taken after reset opens a frame. Each frame is judged on its own. While the fourth bit of a frame is being presented, the hit output reports whether the whole frame equals one of two accepted words. After that fourth bit the checker always starts a fresh frame, whether the frame matched or not. It never searches a sliding window.

The decision is Mealy type. The hit flag comes from the recorded history of the first three bits and from the bit present on the input in that same cycle, with no register in between. The stream sides use a valid/ready handshake. Each incoming bit produces exactly one result on the output side in the same cycle, so back-pressure passes straight through: `in_ready` follows `out_ready`. A bit is taken, and the frame advances, only in a cycle where `in_valid` and `out_ready` are both high. Otherwise the checker holds its position and its history unchanged.

Top module: `framed_pattern_checker`

## Requirements
- R1: A synchronous reset (`rst_sync` high at a rising clock edge) returns the checker to the start of a frame. The first bit accepted after reset is bit 1 of a frame, even if reset arrives in the middle of a frame.
- R2: Accepted bits are grouped into consecutive, non-overlapping frames of four. The first accepted bit of a frame is the leftmost (most significant) bit of the four-bit word compared.
- R3: In the cycle in which the fourth bit of a frame is presented with `in_valid` high, `out_hit` is 1 exactly when the frame word is 4'b0101 or 4'b1001. For every other word it is 0.
- R4: `out_hit` is 0 while bits 1, 2 and 3 of a frame are presented, whatever their values.
- R5: After the fourth bit is accepted, the next accepted bit is bit 1 of a new frame, whether or not the previous frame matched.
- R6: `out_hit` responds to `in_bit` within the same cycle (Mealy output). Changing `in_bit` during the fourth-bit cycle changes `out_hit` before the next clock edge.
- R7: `in_ready` equals `out_ready`, and `out_valid` equals `in_valid`. A bit is accepted only in a cycle where `in_valid` and `out_ready` are both 1.
- R8: In a cycle where no bit is accepted, the frame position and the bit history do not change. A stalled bit is presented again and is then treated as the same frame position.
- R9: `out_hit` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming bit is present |
| in_ready | output | 1 | Checker can take a bit (follows out_ready) |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Result for the presented bit is present |
| out_ready | input | 1 | Consumer accepts the result |
| out_hit | output | 1 | Frame matched; meaningful on a frame's fourth bit |

## Verification
On every cycle, the assertions check four things. First, a hit occurs only at the last frame position, as kept by a position counter that is separate from the state machine. Second, the machine is at its start state exactly when that counter is at zero. Third, a stall leaves both the position and the history unchanged. Fourth, the checker returns to the start after the last bit and after reset. Whether the accepted words really are 0101 and 1001, that the bit order is leftmost-first, and that the Mealy output changes within the cycle can only be shown by the bench's scenarios. These are a sweep of all sixteen words back to back, random frames with stalls and idle gaps, a reset in the middle of a frame, and an input toggle inside one cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int FRAME_LEN = 4;
  localparam int POS_W     = $clog2(FRAME_LEN);

  // History states: H<bits seen>, DEAD<n> = n bits seen, no match possible
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_H0,
    ST_H1,
    ST_H01,
    ST_H10,
    ST_H010,
    ST_H100,
    ST_DEAD2,
    ST_DEAD3
  } fpc_state_e;
endpackage

// File: rtl/fpc_frame_pos.sv
module fpc_frame_pos
  import fpc_pkg::*;
#(
  parameter int LEN = FRAME_LEN,
  localparam int PW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_sync,
  input  logic          advance,
  output logic [PW-1:0] pos,
  output logic          last
);
  localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst_sync)           pos_q <= '0;
    else if (advance) begin
      if (pos_q == LAST_POS) pos_q <= '0;
      else                   pos_q <= pos_q + 1'b1;
    end
  end

  assign pos  = pos_q;
  assign last = (pos_q == LAST_POS);

  // R8: position holds while nothing is accepted
  assert_pos_hold_R8: assert property (@(posedge clk) disable iff (rst_sync)
    !advance |=> $stable(pos_q));
  // R1: reset puts the position at frame start
  assert_pos_reset_R1: assert property (@(posedge clk)
    rst_sync |=> (pos_q == '0));
endmodule

// File: rtl/fpc_next_state.sv
module fpc_next_state
  import fpc_pkg::*;
(
  input  fpc_state_e cur,
  input  logic       bit_in,
  output fpc_state_e nxt,
  output logic       hit_cand
);
  always_comb begin
    nxt      = ST_IDLE;
    hit_cand = 1'b0;
    unique case (cur)
      ST_IDLE:  nxt = bit_in ? ST_H1 : ST_H0;
      ST_H0:    nxt = bit_in ? ST_H01 : ST_DEAD2;
      ST_H1:    nxt = bit_in ? ST_DEAD2 : ST_H10;
      ST_H01:   nxt = bit_in ? ST_DEAD3 : ST_H010;
      ST_H10:   nxt = bit_in ? ST_DEAD3 : ST_H100;
      ST_DEAD2: nxt = ST_DEAD3;
      ST_H010: begin nxt = ST_IDLE; hit_cand = bit_in; end
      ST_H100: begin nxt = ST_IDLE; hit_cand = bit_in; end
      ST_DEAD3: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fpc_state_reg.sv
module fpc_state_reg
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync,
  input  logic       advance,
  input  logic       frame_last,
  input  fpc_state_e nxt,
  output fpc_state_e cur
);
  fpc_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst_sync)     state_q <= ST_IDLE;
    else if (advance) state_q <= nxt;
  end

  assign cur = state_q;

  // R5: after the last bit of a frame the machine is back at start
  assert_frame_restart_R5: assert property (@(posedge clk) disable iff (rst_sync)
    (advance && frame_last) |=> (state_q == ST_IDLE));
  // R8: history holds during a stall
  assert_state_hold_R8: assert property (@(posedge clk) disable iff (rst_sync)
    !advance |=> $stable(state_q));
  // R1: reset returns to frame start
  assert_state_reset_R1: assert property (@(posedge clk)
    rst_sync |=> (state_q == ST_IDLE));
endmodule

// File: rtl/framed_pattern_checker.sv
module framed_pattern_checker
  import fpc_pkg::*;
(
  input  logic clk,
  input  logic rst_sync,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_hit
);
  logic             accept;
  logic [POS_W-1:0] pos;
  logic             pos_last;
  fpc_state_e       cur_st, nxt_st;
  logic             hit_cand;

  assign accept    = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_hit   = in_valid & hit_cand;

  fpc_frame_pos #(.LEN(FRAME_LEN)) pos_i (
    .clk(clk), .rst_sync(rst_sync), .advance(accept),
    .pos(pos), .last(pos_last)
  );

  fpc_next_state ns_i (
    .cur(cur_st), .bit_in(in_bit), .nxt(nxt_st), .hit_cand(hit_cand)
  );

  fpc_state_reg sr_i (
    .clk(clk), .rst_sync(rst_sync), .advance(accept),
    .frame_last(pos_last), .nxt(nxt_st), .cur(cur_st)
  );

  // R4: a hit can only appear at the last frame position
  assert_hit_on_last_R4: assert property (@(posedge clk) disable iff (rst_sync)
    out_hit |-> pos_last);
  // R2: state machine and position counter agree on frame start
  assert_start_aligned_R2: assert property (@(posedge clk) disable iff (rst_sync)
    (cur_st == ST_IDLE) == (pos == '0));
  // R9: no hit without a valid result
  assert_hit_qualified_R9: assert property (@(posedge clk) disable iff (rst_sync)
    out_hit |-> out_valid);
endmodule

// File: tb/framed_pattern_checker_tb_top.sv
module framed_pattern_checker_tb_top;
  logic clk = 1'b0;
  logic rst_sync = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_hit;
  int n_checks = 0, n_fail = 0;
  int m_pos = 0;
  logic [2:0] m_hist = '0;
  bit done = 0;

  always #10 clk = ~clk;

  framed_pattern_checker dut_i (
    .clk(clk), .rst_sync(rst_sync), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic b);
    logic [3:0] w;
    w = {m_hist, b};
    return (m_pos == 3) && (w == 4'b0101 || w == 4'b1001);
  endfunction

  // Present one bit; stall=1 holds out_ready low for that cycle
  task automatic drive(input logic v, input logic b, input logic stall);
    @(negedge clk);
    in_valid = v; in_bit = b; out_ready = !stall;
    #2;
    check("R7", in_ready, !stall);
    check("R7", out_valid, v);
    if (!v) check("R9", out_hit, 1'b0);
    else if (m_pos == 3) check("R3", out_hit, model_hit(b));
    else check("R4", out_hit, 1'b0);
    @(posedge clk);
    if (v && !stall) begin
      m_hist = {m_hist[1:0], b};
      m_pos  = (m_pos + 1) % 4;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_sync = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    rst_sync = 1'b0;
    m_pos = 0; m_hist = '0;
  endtask

  initial begin
    do_reset();
    #2;
    check("R1", out_hit, 1'b0);
    check("R1", out_valid, 1'b0);
    // R2 R3 R5: all sixteen words back to back, leftmost bit first
    for (int rep = 0; rep < 2; rep++)
      for (int w = 0; w < 16; w++)
        for (int k = 3; k >= 0; k--) drive(1'b1, w[k], 1'b0);
    // R8 R9: random frames with stalls and idle gaps
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) drive(1'b0, 1'($urandom_range(0, 1)), 1'b0);
      else if (r == 1) drive(1'b1, 1'($urandom_range(0, 1)), 1'b1);
      else drive(1'b1, 1'($urandom_range(0, 1)), 1'b0);
    end
    // R8: stall on a fourth bit then present it again
    while (m_pos != 0) drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0); drive(1'b1, 1'b0, 1'b0); drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    // R1: reset mid-frame, then 0101 must hit on its fourth bit
    drive(1'b1, 1'b1, 1'b0); drive(1'b1, 1'b0, 1'b0);
    do_reset();
    drive(1'b1, 1'b0, 1'b0); drive(1'b1, 1'b1, 1'b0); drive(1'b1, 1'b0, 1'b0);
    // R6: toggle in_bit within the fourth-bit cycle
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; in_bit = 1'b0;
    #2 check("R6", out_hit, 1'b0);
    in_bit = 1'b1;
    #2 check("R6", out_hit, 1'b1);
    @(posedge clk);
    m_pos = 0; m_hist = '0;
    // R5: next word after a hit is a fresh frame (1001)
    drive(1'b1, 1'b1, 1'b0); drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0); drive(1'b1, 1'b1, 1'b0);
    check("R5", 1'(m_pos == 0), 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule